// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Register

This block merges nine separate reset requests into one active-high system reset. The requests are power-on, the external reset pin, a software reset instruction, a watchdog timeout, brown-out, a configuration mismatch, a trap conflict, an illegal opcode and a read of an uninitialized working register. All but the pin are active-high digital requests. The pin is active low and asynchronous. It is synchronized and then debounced, so a short low glitch cannot reset the chip. When the last request goes away, the system reset is held for a fixed number of clocks and then released on a clock edge.

Next to the reset path, a nine-bit cause register records which sources have fired. Software can read it and overwrite it at any time. Each bit is sticky and only software clears it, except on power-on. Power-on loads a fixed pattern: power-on and brown-out set, all other bits clear. A software write only changes status and never starts a reset.

Top module: `reset_hub`

## Requirements
- R1: Any high level on `soft_rst_i`, `wdog_i`, `brownout_i`, `cfg_mismatch_i`, `trap_conflict_i`, `bad_opcode_i`, `uninit_reg_i` or `por_i` drives `sys_rst_o` high in the same cycle, with no clock edge in between.
- R2: `ext_rst_n_i` passes through a 2-stage synchronizer and a run-length filter. If the pin is sampled low at rising edges k, k+1, k+2 and k+3, `sys_rst_o` goes high right after edge k+5.
- R3: If the pin is sampled low at no more than 3 consecutive rising edges, `sys_rst_o` stays low and cause bit 8 stays clear.
- R4: Let e be the last rising edge at which any source was sampled active. `sys_rst_o` stays high after edges e+1 to e+15 and goes low after edge e+16, so it is released only by a clock edge.
- R5: A source sampled active at a rising edge sets its cause bit after that edge. The bit positions are: 1 brown-out, 2 watchdog, 3 software, 4 configuration mismatch, 5 trap conflict, 6 illegal opcode, 7 uninitialized register, 8 external pin.
- R6: After an edge where `por_i` is sampled high, `cause_o` equals 0x003: bit 0 (power-on) and bit 1 (brown-out) set, every other bit clear.
- R7: A set cause bit stays set through later non-power-on resets and idle cycles until software writes it.
- R8: If `wr_en_i` is high at a rising edge, `cause_o` takes the value of `wr_data_i` after that edge. `cause_o` always shows the register contents.
- R9: A software write, even one that sets every cause bit, never drives `sys_rst_o` high.
- R10: If a source event and a write hit the same bit at the same edge, the bit ends up set. The other bits take the written value.
- R11: Power-on overrides both a write and any other source at the same edge, and the result is 0x003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on request, active high, also resets internal state |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| soft_rst_i | input | 1 | Software reset instruction request |
| wdog_i | input | 1 | Watchdog timeout request |
| brownout_i | input | 1 | Brown-out request |
| cfg_mismatch_i | input | 1 | Configuration mismatch request |
| trap_conflict_i | input | 1 | Trap conflict request |
| bad_opcode_i | input | 1 | Illegal opcode request |
| uninit_reg_i | input | 1 | Uninitialized working register request |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 9 | Cause register write data |
| cause_o | output | 9 | Cause register read data |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
Each result has its own timing. A level request shows on `sys_rst_o` in the same cycle. A cause bit or a write result shows after the edge that samples it. A pin pulse reaches the reset output two edges after its fourth low sample, and the stretched release comes exactly sixteen edges after the last active sample. The bench drives inputs on falling edges and counts falling edges from the point where a stimulus is removed. It checks each output only at the falling edge where the count above says the output should change. The bench also samples the cycle just before each release, so an off-by-one in the stretch counter or the filter shows up as a mismatch.

// File: rtl/rsth_pkg.sv
package rsth_pkg;
   localparam int unsigned NUM_CAUSES = 9;

   typedef enum int unsigned {
      CZ_POR   = 0,
      CZ_BOR   = 1,
      CZ_WDOG  = 2,
      CZ_SOFT  = 3,
      CZ_CFG   = 4,
      CZ_TRAP  = 5,
      CZ_OPC   = 6,
      CZ_UNINIT = 7,
      CZ_PIN   = 8
   } cause_idx_e;

   typedef logic [NUM_CAUSES-1:0] cause_vec_t;

   localparam cause_vec_t POR_PATTERN = cause_vec_t'((1 << CZ_POR) | (1 << CZ_BOR));
endpackage

// File: rtl/rsth_pin_filter.sv
module rsth_pin_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic pin_n_i,
   output logic hit_o
);
   localparam int unsigned CW = $clog2(FILT_LEN + 1);

   logic          sampled;
   logic [CW-1:0] run_q;

   if (FILT_LEN < 1) begin : g_bad_len
      $error("rsth_pin_filter: FILT_LEN must be at least 1");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign sampled = pin_n_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] stage_q;
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (clr_i) stage_q[0] <= 1'b1;
               else       stage_q[0] <= pin_n_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (clr_i) stage_q[s] <= 1'b1;
               else       stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign sampled = stage_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk_i) begin
      if (clr_i || sampled)           run_q <= '0;
      else if (run_q != CW'(FILT_LEN)) run_q <= run_q + 1'b1;
   end

   assign hit_o = (run_q == CW'(FILT_LEN));

   // R3: a high sample ends any filtered hit on the next cycle
   p_high_clears_r3: assert property (@(posedge clk_i) disable iff (clr_i)
      sampled |=> !hit_o);

   // R2: a hit can only begin after a low sample
   p_hit_needs_low_r2: assert property (@(posedge clk_i) disable iff (clr_i)
      $rose(hit_o) |-> !$past(sampled));
endmodule

// File: rtl/rsth_stretch.sv
module rsth_stretch #(
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic clk_i,
   input  logic clr_i,
   input  logic req_i,
   output logic rst_o
);
   localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

   logic [HW-1:0] hold_q;

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("rsth_stretch: HOLD_CYCLES must be at least 1");
   end

   always_ff @(posedge clk_i) begin
      if (req_i)            hold_q <= HW'(HOLD_CYCLES);
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
   end

   assign rst_o = req_i | (hold_q != '0);

   // R4: reset is still held in the cycle right after the request drops
   p_hold_after_drop_r4: assert property (@(posedge clk_i) disable iff (clr_i)
      $fell(req_i) |-> rst_o);

   // R4: release only happens once the hold count has run down
   p_release_at_end_r4: assert property (@(posedge clk_i) disable iff (clr_i)
      $fell(rst_o) |-> ($past(hold_q) == HW'(1)) && !$past(req_i));
endmodule

// File: rtl/rsth_cause_reg.sv
module rsth_cause_reg
   import rsth_pkg::*;
(
   input  logic       clk_i,
   input  logic       clr_i,
   input  cause_vec_t set_i,
   input  logic       wr_i,
   input  cause_vec_t wdata_i,
   output cause_vec_t q_o
);
   cause_vec_t base;

   assign base = wr_i ? wdata_i : q_o;

   always_ff @(posedge clk_i) begin
      if (clr_i) q_o <= POR_PATTERN;
      else       q_o <= base | set_i;
   end

   // R6: power-on leaves exactly the power-on pattern
   p_por_pattern_r6: assert property (@(posedge clk_i) disable iff (clr_i)
      $fell(clr_i) |-> (q_o == POR_PATTERN));

   // R7: without a write no bit ever clears
   p_sticky_r7: assert property (@(posedge clk_i) disable iff (clr_i)
      (!$past(wr_i) && !$past(clr_i)) |-> ((q_o & $past(q_o)) == $past(q_o)));

   // R10: every hardware event lands even against a write
   p_hw_wins_r10: assert property (@(posedge clk_i) disable iff (clr_i)
      !$past(clr_i) |-> (($past(set_i) & ~q_o) == '0));
endmodule

// File: rtl/reset_hub.sv
module reset_hub
   import rsth_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic                  clk_i,
   input  logic                  por_i,
   input  logic                  ext_rst_n_i,
   input  logic                  soft_rst_i,
   input  logic                  wdog_i,
   input  logic                  brownout_i,
   input  logic                  cfg_mismatch_i,
   input  logic                  trap_conflict_i,
   input  logic                  bad_opcode_i,
   input  logic                  uninit_reg_i,
   input  logic                  wr_en_i,
   input  logic [NUM_CAUSES-1:0] wr_data_i,
   output logic [NUM_CAUSES-1:0] cause_o,
   output logic                  sys_rst_o
);
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("reset_hub: SYNC_STAGES above 4 is not supported");
   end

   logic       pin_hit;
   logic       any_req;
   cause_vec_t set_vec;

   rsth_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) i_filter (
      .clk_i  (clk_i),
      .clr_i  (por_i),
      .pin_n_i(ext_rst_n_i),
      .hit_o  (pin_hit)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[CZ_BOR]    = brownout_i;
      set_vec[CZ_WDOG]   = wdog_i;
      set_vec[CZ_SOFT]   = soft_rst_i;
      set_vec[CZ_CFG]    = cfg_mismatch_i;
      set_vec[CZ_TRAP]   = trap_conflict_i;
      set_vec[CZ_OPC]    = bad_opcode_i;
      set_vec[CZ_UNINIT] = uninit_reg_i;
      set_vec[CZ_PIN]    = pin_hit;
   end

   assign any_req = por_i | (|set_vec);

   rsth_stretch #(
      .HOLD_CYCLES(HOLD_CYCLES)
   ) i_stretch (
      .clk_i(clk_i),
      .clr_i(por_i),
      .req_i(any_req),
      .rst_o(sys_rst_o)
   );

   rsth_cause_reg i_cause (
      .clk_i  (clk_i),
      .clr_i  (por_i),
      .set_i  (set_vec),
      .wr_i   (wr_en_i),
      .wdata_i(wr_data_i),
      .q_o    (cause_o)
   );

   // R1: any level request at the ports holds the system reset active
   p_any_source_r1: assert property (@(posedge clk_i) disable iff (por_i)
      (soft_rst_i | wdog_i | brownout_i | cfg_mismatch_i | trap_conflict_i
       | bad_opcode_i | uninit_reg_i) |-> sys_rst_o);

   // R2: a filtered pin event is both a reset and a recorded cause
   p_pin_both_r2: assert property (@(posedge clk_i) disable iff (por_i)
      pin_hit |=> (sys_rst_o && cause_o[CZ_PIN]));
endmodule

// File: tb/test_reset_hub.sv
module test_reset_hub;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       pin_n = 1'b1;
   logic [6:0] req = '0;
   logic       wr = 1'b0;
   logic [8:0] wdata = '0;
   logic [8:0] cause;
   logic       sys_rst;

   int checks = 0;
   int fails  = 0;

   // request order: soft, wdog, brownout, cfg, trap, opcode, uninit
   int bitpos [7] = '{3, 2, 1, 4, 5, 6, 7};

   always #(CLK_PERIOD/2) clk = ~clk;

   reset_hub i_reset_hub (
      .clk_i          (clk),
      .por_i          (por),
      .ext_rst_n_i    (pin_n),
      .soft_rst_i     (req[0]),
      .wdog_i         (req[1]),
      .brownout_i     (req[2]),
      .cfg_mismatch_i (req[3]),
      .trap_conflict_i(req[4]),
      .bad_opcode_i   (req[5]),
      .uninit_reg_i   (req[6]),
      .wr_en_i        (wr),
      .wr_data_i      (wdata),
      .cause_o        (cause),
      .sys_rst_o      (sys_rst)
   );

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // stimulus was just removed at this falling edge
   task automatic expect_release(input string tag);
      #1 chk({tag, " R4 held at drop"}, 9'(sys_rst), 9'd1);
      for (int j = 1; j <= 16; j++) begin
         @(negedge clk);
         if (j == 15) chk({tag, " R4 held at 15"}, 9'(sys_rst), 9'd1);
         if (j == 16) chk({tag, " R4 released at 16"}, 9'(sys_rst), 9'd0);
      end
   endtask

   task automatic write_cause(input logic [8:0] v);
      wr = 1'b1; wdata = v;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic t_power_on;
      @(negedge clk); @(negedge clk);
      chk("R6 cause after power-on", cause, 9'h003);
      chk("R1 reset during power-on", 9'(sys_rst), 9'd1);
      por = 1'b0;
      expect_release("power-on");
   endtask

   task automatic t_source(input int i);
      write_cause(9'h000);
      req[i] = 1'b1;
      #1 chk($sformatf("R1 source %0d immediate", i), 9'(sys_rst), 9'd1);
      @(negedge clk);
      req[i] = 1'b0;
      chk($sformatf("R5 source %0d bit", i), cause, 9'(1 << bitpos[i]));
      expect_release($sformatf("source %0d", i));
   endtask

   task automatic t_sticky;
      write_cause(9'h000);
      req[0] = 1'b1; @(negedge clk); req[0] = 1'b0;
      repeat (20) @(negedge clk);
      req[1] = 1'b1; @(negedge clk); req[1] = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 both causes kept", cause, 9'h00C);
   endtask

   task automatic t_pin_short;
      bit seen = 1'b0;
      write_cause(9'h000);
      pin_n = 1'b0;
      repeat (3) @(negedge clk);
      pin_n = 1'b1;
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         if (sys_rst) seen = 1'b1;
      end
      chk("R3 short pulse no reset", 9'(seen), 9'd0);
      chk("R3 short pulse no cause", cause, 9'h000);
   endtask

   task automatic t_pin_long;
      pin_n = 1'b0;
      repeat (4) @(negedge clk);
      pin_n = 1'b1;
      for (int j = 1; j <= 19; j++) begin
         @(negedge clk);
         if (j == 1)  chk("R2 not yet at k+4", 9'(sys_rst), 9'd0);
         if (j == 2)  chk("R2 asserted at k+5", 9'(sys_rst), 9'd1);
         if (j == 3)  chk("R5 pin cause bit", cause, 9'h100);
         if (j == 18) chk("R4 pin held", 9'(sys_rst), 9'd1);
         if (j == 19) chk("R4 pin released", 9'(sys_rst), 9'd0);
      end
   endtask

   task automatic t_write_only;
      bit seen = 1'b0;
      wr = 1'b1; wdata = 9'h1FF;
      #1 if (sys_rst) seen = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      chk("R8 write value", cause, 9'h1FF);
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         if (sys_rst) seen = 1'b1;
      end
      chk("R9 write causes no reset", 9'(seen), 9'd0);
      chk("R8 value kept", cause, 9'h1FF);
   endtask

   task automatic t_collision;
      wr = 1'b1; wdata = 9'h000; req[1] = 1'b1;
      @(negedge clk);
      wr = 1'b0; req[1] = 1'b0;
      chk("R10 hardware set wins", cause, 9'h004);
      expect_release("collision");
   endtask

   task automatic t_por_priority;
      por = 1'b1; wr = 1'b1; wdata = 9'h1F0; req[0] = 1'b1;
      @(negedge clk);
      por = 1'b0; wr = 1'b0; req[0] = 1'b0;
      chk("R11 power-on overrides", cause, 9'h003);
      expect_release("por priority");
   endtask

   task automatic run_all;
      t_power_on();
      for (int i = 0; i < 7; i++) t_source(i);
      t_sticky();
      t_pin_short();
      t_pin_long();
      t_write_only();
      t_collision();
      t_por_priority();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule